// File: doc/BRIEF.md
# I2C Target Front End with Persistent Register Pointer

This block is the serial-side front end of a small 8-bit port expander. It runs entirely on the system clock. It oversamples the two-wire bus lines through a short synchronizer and recognises start and stop conditions. It accepts a 7-bit target address made of a fixed 4-bit prefix and three strap inputs, and it acknowledges matching address bytes and every byte written to it. The bus data line is never driven high. The block only asserts a pull-low enable, which the pad logic turns into an open-drain driver.

In a write transaction, the first byte after the address selects one of the expander's registers. That selection is kept in a pointer register that outlives the transaction. Every further byte in the same write produces a one-cycle write strobe on a simple register bus. In a read transaction, the block takes the byte for the current pointer from the register bus at the start of each byte, shifts it out most significant bit first, and keeps sending as long as the controller acknowledges. A controller that wants to read a different register first writes a new pointer and then uses a repeated start to turn the transfer into a read.

Top module: `i2c_ptr_target`

## Requirements
- R1: While reset is asserted, `sda_pull_o` is 0, `reg_we_o` is 0 and `reg_addr_o` is 0 (the pointer's reset value).
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Before the first start, and after a stop, clocked bytes get no acknowledge and cause no write strobe.
- R3: The target address is {4'b0100, strap_i[2:0]}, carried in bits 7..1 of the first byte after a start, most significant bit first. Bit 0 of that byte selects the direction: 1 is read, 0 is write. On a mismatch the block gives no acknowledge and ignores the bus until the next start.
- R4: For a matching address, and for every byte received in a write transaction, the block holds the data line low during the ninth clock pulse.
- R5: The first byte of a write transaction loads the pointer from its bits 1..0, and bits 7..2 are ignored. `reg_addr_o` shows the pointer at all times, and nothing else changes it.
- R6: Each later byte of a write transaction gives exactly one cycle of `reg_we_o`, with that byte on `reg_wdata_o`, while `reg_addr_o` holds the pointer.
- R7: In a read transaction, the block takes `reg_rdata_i` when each byte's shift begins and sends it MSB first. It releases the line in the ninth clock. An acknowledge (line low) starts another byte. A no-acknowledge leaves the line released until the next start or stop.
- R8: The pointer survives stop and start conditions, so a read with no new pointer byte returns the register that was selected last.
- R9: `sda_pull_o` changes only while the synchronized clock line is low, except for the release forced by a start or stop.
- R10: Any start, including a repeated start in the middle of a byte, drops the partial byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Strap pins that form the low three address bits |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| reg_addr_o | output | 2 | Register pointer presented to the register bus |
| reg_wdata_o | output | 8 | Write data for the register bus |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data for the register selected by `reg_addr_o` |

## Verification
The bench goes after the pointer semantics. It uses pointer bytes with high bits set, checks that the pointer survives a stop, and combines a pointer write with a repeated start into a read. A design that used the whole byte as the pointer, or that cleared the pointer at a stop, would return the wrong register. It also sends a repeated start in the middle of a byte and checks that only the restarted transaction writes, which catches a bit counter that is not cleared. Other tests clock bytes before any start, send a wrong strap address, change the read data between acknowledged bytes, and clock the bus after a no-acknowledge. These catch a block that answers without a start, ignores the straps, prefetches stale data, or keeps driving after the controller has ended the read.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_BYTE,
      ST_WR_ACK,
      ST_RD_BYTE,
      ST_RD_ACK,
      ST_WAIT_STOP
   } tgt_state_t;

   // Synchronized bus levels and single-cycle events
   typedef struct packed {
      logic scl_lvl;
      logic sda_lvl;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_evt_t;

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler
   import i2c_ptr_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output bus_evt_t evt_o
);

   localparam int LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("i2c_bus_sampler: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [LAST:0] scl_sh;
   logic [LAST:0] sda_sh;
   logic          scl_q;
   logic          sda_q;
   logic          scl_s;
   logic          sda_s;

   // Synchronizer chain, one flop per stage, idle-high reset
   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_sh[0] <= 1'b1;
                  sda_sh[0] <= 1'b1;
               end else begin
                  scl_sh[0] <= scl_i;
                  sda_sh[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_sh[g] <= 1'b1;
                  sda_sh[g] <= 1'b1;
               end else begin
                  scl_sh[g] <= scl_sh[g-1];
                  sda_sh[g] <= sda_sh[g-1];
               end
            end
         end
      end
   endgenerate

   assign scl_s = scl_sh[LAST];
   assign sda_s = sda_sh[LAST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      evt_o.scl_lvl  = scl_s;
      evt_o.sda_lvl  = sda_s;
      evt_o.scl_rise = scl_s & ~scl_q;
      evt_o.scl_fall = ~scl_s & scl_q;
      evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
      evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
   end

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
   import i2c_ptr_pkg::*;
#(
   parameter int             DATA_W        = 8,
   parameter int             PTR_W         = 2,
   parameter int             STRAP_W       = 3,
   parameter int             ADDR_PREFIX_W = 4,
   parameter logic [ADDR_PREFIX_W-1:0] ADDR_PREFIX = 4'b0100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  bus_evt_t           evt_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic [DATA_W-1:0]  rdata_i,
   output logic               pull_o,
   output logic [PTR_W-1:0]   ptr_o,
   output logic [DATA_W-1:0]  wdata_o,
   output logic               we_o,
   output tgt_state_t         state_o
);

   localparam int DEV_W = ADDR_PREFIX_W + STRAP_W;
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

   generate
      if (DEV_W != DATA_W - 1) begin : g_bad_addr
         $error("i2c_target_ctrl: prefix plus strap width must be DATA_W-1");
      end
      if (PTR_W > DATA_W) begin : g_bad_ptr
         $error("i2c_target_ctrl: PTR_W must not exceed DATA_W");
      end
   endgenerate

   tgt_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] tx_sh;
   logic              pull;
   logic [PTR_W-1:0]  ptr;
   logic [DATA_W-1:0] wdata;
   logic              we;
   logic              first_byte;
   logic              ack_smp;

   logic [DEV_W-1:0]  dev_addr;
   logic              addr_hit;
   logic              byte_done;

   assign dev_addr  = {ADDR_PREFIX, strap_i};
   assign addr_hit  = (rx_sh[DATA_W-1 -: DEV_W] == dev_addr);
   assign byte_done = evt_i.scl_fall && (cnt == FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         rx_sh      <= '0;
         tx_sh      <= '0;
         pull       <= 1'b0;
         ptr        <= '0;
         wdata      <= '0;
         we         <= 1'b0;
         first_byte <= 1'b0;
         ack_smp    <= 1'b1;
      end else begin
         we <= 1'b0;
         if (evt_i.start) begin
            state <= ST_ADDR;
            cnt   <= '0;
            pull  <= 1'b0;
         end else if (evt_i.stop) begin
            state <= ST_IDLE;
            cnt   <= '0;
            pull  <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_WR_BYTE: begin
                  if (evt_i.scl_rise && cnt != FULL) begin
                     rx_sh <= {rx_sh[DATA_W-2:0], evt_i.sda_lvl};
                     cnt   <= cnt + 1'b1;
                  end
                  if (byte_done) begin
                     if (state == ST_ADDR) begin
                        if (addr_hit) begin
                           pull  <= 1'b1;
                           state <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_WAIT_STOP;
                        end
                     end else begin
                        pull  <= 1'b1;
                        state <= ST_WR_ACK;
                        if (first_byte) begin
                           ptr        <= rx_sh[PTR_W-1:0];
                           first_byte <= 1'b0;
                        end else begin
                           wdata <= rx_sh;
                           we    <= 1'b1;
                        end
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (evt_i.scl_fall) begin
                     cnt <= '0;
                     if (rx_sh[0]) begin
                        tx_sh <= rdata_i;
                        pull  <= ~rdata_i[DATA_W-1];
                        state <= ST_RD_BYTE;
                     end else begin
                        pull       <= 1'b0;
                        first_byte <= 1'b1;
                        state      <= ST_WR_BYTE;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (evt_i.scl_fall) begin
                     pull  <= 1'b0;
                     cnt   <= '0;
                     state <= ST_WR_BYTE;
                  end
               end
               ST_RD_BYTE: begin
                  if (evt_i.scl_rise && cnt != FULL) begin
                     cnt <= cnt + 1'b1;
                  end
                  if (evt_i.scl_fall) begin
                     if (cnt == FULL) begin
                        pull  <= 1'b0;
                        state <= ST_RD_ACK;
                     end else begin
                        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                        pull  <= ~tx_sh[DATA_W-2];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (evt_i.scl_rise) begin
                     ack_smp <= evt_i.sda_lvl;
                  end
                  if (evt_i.scl_fall) begin
                     if (!ack_smp) begin
                        tx_sh <= rdata_i;
                        pull  <= ~rdata_i[DATA_W-1];
                        cnt   <= '0;
                        state <= ST_RD_BYTE;
                     end else begin
                        state <= ST_WAIT_STOP;
                     end
                  end
               end
               default: begin
                  pull <= 1'b0;
               end
            endcase
         end
      end
   end

   assign pull_o  = pull;
   assign ptr_o   = ptr;
   assign wdata_o = wdata;
   assign we_o    = we;
   assign state_o = state;

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
   import i2c_ptr_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int PTR_W         = 2,
   parameter int STRAP_W       = 3,
   parameter int ADDR_PREFIX_W = 4,
   parameter logic [ADDR_PREFIX_W-1:0] ADDR_PREFIX = 4'b0100,
   parameter int SYNC_STAGES   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   output logic               sda_pull_o,
   output logic [PTR_W-1:0]   reg_addr_o,
   output logic [DATA_W-1:0]  reg_wdata_o,
   output logic               reg_we_o,
   input  logic [DATA_W-1:0]  reg_rdata_i
);

   bus_evt_t   bus_evt;
   tgt_state_t ctl_state;

   i2c_bus_sampler #(
      .SYNC_STAGES(SYNC_STAGES)
   ) i_sampler (
      .clk  (clk),
      .rst_n(rst_n),
      .scl_i(scl_i),
      .sda_i(sda_i),
      .evt_o(bus_evt)
   );

   i2c_target_ctrl #(
      .DATA_W       (DATA_W),
      .PTR_W        (PTR_W),
      .STRAP_W      (STRAP_W),
      .ADDR_PREFIX_W(ADDR_PREFIX_W),
      .ADDR_PREFIX  (ADDR_PREFIX)
   ) i_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (bus_evt),
      .strap_i(strap_i),
      .rdata_i(reg_rdata_i),
      .pull_o (sda_pull_o),
      .ptr_o  (reg_addr_o),
      .wdata_o(reg_wdata_o),
      .we_o   (reg_we_o),
      .state_o(ctl_state)
   );

endmodule

// File: rtl/i2c_ptr_target_chk.sv
module i2c_ptr_target_chk
   import i2c_ptr_pkg::*;
#(
   parameter int PTR_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input bus_evt_t         evt,
   input tgt_state_t       state,
   input logic             sda_pull,
   input logic             reg_we,
   input logic [PTR_W-1:0] reg_addr
);

   // R1: outputs quiet while reset is held
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (!sda_pull && !reg_we && reg_addr == '0)
            else $error("R1 outputs active during reset");
      end
   end

   // R2: no drive while idle or waiting for stop
   a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE || state == ST_WAIT_STOP) |-> !sda_pull);

   // R5: the pointer only moves at the end of a write byte
   a_r5_ptr_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_addr) |-> ($past(state) == ST_WR_BYTE && state == ST_WR_ACK));

   // R6: strobe is one cycle wide
   a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R6: strobe only in the acknowledge slot of a write data byte
   a_r6_strobe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (state == ST_WR_ACK && $stable(reg_addr)));

   // R7: line released while the controller acknowledges a read byte
   a_r7_rd_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_RD_ACK |-> !sda_pull);

   // R9: drive changes only while the clock line is low
   a_r9_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_pull) && !$past(evt.start) && !$past(evt.stop)) |-> !evt.scl_lvl);

endmodule

bind i2c_ptr_target i2c_ptr_target_chk #(.PTR_W(PTR_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .evt     (bus_evt),
   .state   (ctl_state),
   .sda_pull(sda_pull_o),
   .reg_we  (reg_we_o),
   .reg_addr(reg_addr_o)
);

// File: tb/test_i2c_ptr_target.sv
`timescale 1ns/1ps
module test_i2c_ptr_target;

   localparam int Q = 8;                 // clocks per quarter bus bit
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] ADR_W = 8'h4A;  // {0100,101,0}
   localparam logic [7:0] ADR_R = 8'h4B;
   localparam logic [7:0] ADR_BAD = 8'h46;
   localparam int NVEC = 4;
   // {pointer byte, data byte}
   localparam logic [15:0] VEC [NVEC] = '{16'h015A, 16'h02C3, 16'h030F, 16'hFDA5};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_bus;
   logic       sda_pull;
   logic [1:0] reg_addr;
   logic [7:0] reg_wdata;
   logic       reg_we;
   logic [7:0] reg_rdata;
   logic [7:0] mem [4];
   int         we_cnt = 0;
   int         checks = 0;
   int         errors = 0;

   always #2.5 clk = ~clk;

   assign sda_bus   = sda_m & ~sda_pull;
   assign reg_rdata = mem[reg_addr];

   always @(posedge clk) begin
      if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
         we_cnt <= we_cnt + 1;
      end
   end

   i2c_ptr_target i_i2c_ptr_target (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_bus),
      .strap_i    (STRAP),
      .sda_pull_o (sda_pull),
      .reg_addr_o (reg_addr),
      .reg_wdata_o(reg_wdata),
      .reg_we_o   (reg_we),
      .reg_rdata_i(reg_rdata)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic waitq();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; waitq();
      scl = 1'b1;   waitq();
      sda_m = 1'b0; waitq();
      scl = 1'b0;   waitq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; waitq();
      scl = 1'b1;   waitq();
      sda_m = 1'b1; waitq();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; waitq();
         scl = 1'b1;   waitq(); waitq();
         scl = 1'b0;   waitq();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      send_bits(b, 8);
      sda_m = 1'b1; waitq();
      scl = 1'b1;   waitq();
      acked = ~sda_bus;
      waitq();
      scl = 1'b0;
   endtask

   task automatic recv_byte(input logic ack, output logic [7:0] d);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         waitq(); waitq();
         scl = 1'b1; waitq();
         d[i] = sda_bus;
         waitq();
         scl = 1'b0;
      end
      waitq();
      sda_m = ~ack; waitq();
      scl = 1'b1;   waitq(); waitq();
      scl = 1'b0;
      @(posedge clk); #1;
      sda_m = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic       a0, a1, a2, a3;
      logic [7:0] d;
      int         w0;
      for (int k = 0; k < 4; k++) mem[k] = 8'h90 + 8'(k);
      repeat (5) @(posedge clk); #1;
      chk("R1 pull in reset", 32'(sda_pull), 0);
      chk("R1 strobe in reset", 32'(reg_we), 0);
      chk("R1 pointer in reset", 32'(reg_addr), 0);
      rst_n = 1'b1;
      waitq();

      // R2: bytes without a start are ignored
      scl = 1'b0; waitq();
      w0 = we_cnt;
      send_byte(ADR_W, a0);
      send_byte(8'h01, a1);
      chk("R2 no ack before start", 32'({a0, a1}), 0);
      chk("R2 no strobe before start", 32'(we_cnt - w0), 0);
      bus_stop();

      // Table: write pointer+data, stop, read back with fresh transaction
      for (int v = 0; v < NVEC; v++) begin
         bus_start();
         send_byte(ADR_W, a0);
         send_byte(VEC[v][15:8], a1);
         send_byte(VEC[v][7:0], a2);
         bus_stop();
         chk("R4 acks addr/pointer/data", 32'({a0, a1, a2}), 32'h7);
         chk("R5 pointer from low bits", 32'(reg_addr), 32'(VEC[v][9:8]));
         bus_start();
         send_byte(ADR_R, a3);
         recv_byte(1'b0, d);
         bus_stop();
         chk("R8 read keeps pointer", 32'({a3, d}), 32'({1'b1, VEC[v][7:0]}));
      end

      // R3: wrong strap bits
      w0 = we_cnt;
      bus_start();
      send_byte(ADR_BAD, a0);
      send_byte(8'h01, a1);
      send_byte(8'hEE, a2);
      bus_stop();
      chk("R3 mismatch not acked", 32'({a0, a1, a2}), 0);
      chk("R3 mismatch no strobe", 32'(we_cnt - w0), 0);

      // R6: two data bytes give two strobes to the same register
      w0 = we_cnt;
      bus_start();
      send_byte(ADR_W, a0);
      send_byte(8'h01, a1);
      send_byte(8'h11, a2);
      send_byte(8'h22, a3);
      bus_stop();
      chk("R6 strobe count", 32'(we_cnt - w0), 2);
      chk("R6 last data in reg 1", 32'(mem[1]), 32'h22);
      chk("R6 other reg untouched", 32'(mem[2]), 32'hC3);

      // R7: acknowledged read continues with freshly sampled data
      bus_start();
      send_byte(ADR_R, a0);
      recv_byte(1'b1, d);
      chk("R7 first read byte", 32'(d), 32'h22);
      mem[1] = 8'h3C;
      recv_byte(1'b0, d);
      chk("R7 second byte resampled", 32'(d), 32'h3C);
      // R7: after no-acknowledge the line stays released
      recv_byte(1'b0, d);
      chk("R7 released after nack", 32'(d), 32'hFF);
      bus_stop();

      // R10: pointer write then repeated start into a read
      bus_start();
      send_byte(ADR_W, a0);
      send_byte(8'h02, a1);
      bus_start();
      send_byte(ADR_R, a2);
      recv_byte(1'b0, d);
      bus_stop();
      chk("R10 repeated start read", 32'({a0, a1, a2, d}), 32'({3'b111, 8'hC3}));
      chk("R8 pointer after stop", 32'(reg_addr), 2);

      // R10: repeated start inside a byte drops the partial byte
      w0 = we_cnt;
      bus_start();
      send_byte(ADR_W, a0);
      send_bits(8'h03, 4);
      bus_start();
      send_byte(ADR_W, a1);
      send_byte(8'h03, a2);
      send_byte(8'h77, a3);
      bus_stop();
      chk("R10 restart acks", 32'({a0, a1, a2, a3}), 32'hF);
      chk("R10 single strobe after abort", 32'(we_cnt - w0), 1);
      chk("R10 data in reg 3", 32'(mem[3]), 32'h77);
      chk("R2 released after stop", 32'(sda_pull), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule